// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the serial slave front end of a 1024 x 8 byte-addressable nonvolatile store. The store itself is modelled as a register array. The block oversamples the serial clock, the active-low select and the serial input in the system clock domain. It decodes a one-byte command and collects a two-byte address. It streams read data out most-significant bit first. For writes it gathers incoming bytes into a 32-byte page buffer.

A page is committed to the array only when the select rises cleanly after a complete data byte. The commit runs as a self-timed cycle whose length is a parameter counted in system clocks. While that cycle runs, only the status read is honoured.

Write permission comes from a separate protection block. It sees the target address on `tgt_addr` and answers on `wr_permit`. That block also holds the status register. This block reports the busy flag to it and passes on enable, disable and status-write requests as pulses. The serial output has a separate enable, which stands in for high impedance.

Top module: `spi_mem_ctrl`

## Requirements
- R1: While the select is high, and after reset, `miso_oe` is low and `busy` is low.
- R2: Command 0x03 followed by a 16-bit address returns the stored bytes, most significant bit first. Only the low 10 address bits are used. The input is sampled on rising serial clock edges and the output changes on falling edges, with the clock idling either low or high.
- R3: A read continues for as long as clocks arrive, and the address steps from 0x3FF to 0x000.
- R4: Command 0x02 followed by an address and whole data bytes starts a write cycle when the select rises. `busy` then stays high for exactly WR_CYCLES clocks, `cycle_done` pulses once, and the bytes are in the array afterwards.
- R5: During a write only the low 5 address bits advance, so data wraps to the first byte of the same 32-byte page.
- R6: If the select rises in the middle of a byte, or before any data byte has arrived, no write cycle starts and the array is unchanged.
- R7: If `wr_permit` is low when the select rises, no write cycle starts and the array is unchanged.
- R8: While `busy` is high, every command except 0x05 is ignored: reads give no output, writes do not change the array, and 0x06 gives no pulse.
- R9: Command 0x05 returns, repeated for each further byte, `{stat_hi, busy}`. The busy flag is in bit 0.
- R10: Command 0x06 pulses `cmd_wren` once and command 0x04 pulses `cmd_wrdi` once.
- R11: Command 0x01 pulses `sr_wr_valid` with the first data byte on `sr_wr_data` when the select rises on a byte boundary. A partial byte gives no pulse.
- R12: After an unknown command, the rest of the frame is ignored and `miso_oe` stays low until the select falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| csn | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Drive enable for `miso` |
| stat_hi | input | 7 | Status bits 7..1 from the protection block |
| wr_permit | input | 1 | Protection block grants the pending page write |
| tgt_addr | output | 10 | Current byte address |
| busy | output | 1 | Internal write cycle in progress |
| cycle_done | output | 1 | One-clock pulse when a write cycle ends |
| cmd_wren | output | 1 | One-clock pulse for the enable command |
| cmd_wrdi | output | 1 | One-clock pulse for the disable command |
| sr_wr_valid | output | 1 | One-clock pulse for a status write |
| sr_wr_data | output | 8 | Status byte to write |

## Verification
Most internal faults become visible within one serial byte, because they corrupt the next byte read back or the next status byte:
- A miscounted bit position or a bad page wrap shows as a wrong read byte.
- A lost busy flag or a missed command filter shows as an enable pulse, a changed array byte or an active `miso_oe` during a cycle that should stay silent.

A commit counter that is off by even one clock shows as a `busy` window of the wrong length. A wrong commit decision at select rise shows in the next read of the same address, as a changed or unchanged byte.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRDAT, ST_STAT, ST_DROP
  } spi_st_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/spi_mem_edge.sv
// Synchronises the serial pins and turns their transitions into one-clock events.
module spi_mem_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic mosi_s
);
  logic [SYNC-1:0] sck_sr, cs_sr, mo_sr;
  logic            sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr <= '0;
      cs_sr  <= '1;
      mo_sr  <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_sr <= {sck_sr[SYNC-2:0], sck};
      cs_sr  <= {cs_sr[SYNC-2:0], csn};
      mo_sr  <= {mo_sr[SYNC-2:0], mosi};
      sck_d  <= sck_sr[SYNC-1];
      cs_d   <= cs_sr[SYNC-1];
    end
  end

  assign sck_rise = sck_sr[SYNC-1] & ~sck_d;
  assign sck_fall = ~sck_sr[SYNC-1] & sck_d;
  assign cs_rise  = cs_sr[SYNC-1] & ~cs_d;
  assign cs_fall  = ~cs_sr[SYNC-1] & cs_d;
  assign mosi_s   = mo_sr[SYNC-1];
endmodule

// File: rtl/spi_mem_store.sv
// Page buffer, byte array and self-timed commit. WR_CYCLES must be >= 2**PAGE_W.
module spi_mem_store #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 625000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_clr,
  input  logic                     fill_we,
  input  logic [PAGE_W-1:0]        fill_idx,
  input  logic [7:0]               fill_data,
  input  logic                     start,
  input  logic [ADDR_W-PAGE_W-1:0] start_page,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy,
  output logic                     done
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  logic [7:0]            mem  [DEPTH];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask_q;
  logic [CNT_W-1:0]      cyc_q;
  logic [PAGE_W:0]       cidx_q;
  logic [PG_W-1:0]       page_q;
  logic                  done_q;
  logic                  commit_we;

  assign busy      = (cyc_q != '0);
  assign commit_we = busy && !cidx_q[PAGE_W] && pmask_q[cidx_q[PAGE_W-1:0]];
  assign rd_data   = mem[rd_addr];
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (fill_we) pbuf[fill_idx] <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (commit_we) mem[{page_q, cidx_q[PAGE_W-1:0]}] <= pbuf[cidx_q[PAGE_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask_q <= '0;
      cyc_q   <= '0;
      cidx_q  <= '0;
      page_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= busy && (cyc_q == CNT_W'(1));
      if (fill_clr)     pmask_q <= '0;
      else if (fill_we) pmask_q[fill_idx] <= 1'b1;
      if (start) begin
        cyc_q  <= CNT_W'(WR_CYCLES);
        cidx_q <= '0;
        page_q <= start_page;
      end else if (busy) begin
        cyc_q <= cyc_q - CNT_W'(1);
        if (!cidx_q[PAGE_W]) cidx_q <= cidx_q + (PAGE_W+1)'(1);
      end
    end
  end

  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 625000,
  parameter int SYNC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [6:0]        stat_hi,
  input  logic              wr_permit,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              busy,
  output logic              cycle_done,
  output logic              cmd_wren,
  output logic              cmd_wrdi,
  output logic              sr_wr_valid,
  output logic [7:0]        sr_wr_data
);
  localparam int HI_W = ADDR_W - 8;

  logic sck_rise, sck_fall, cs_rise, cs_fall, mosi_s;

  spi_mem_edge #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .mosi_s(mosi_s)
  );

  spi_st_e           st_q, st_nx;
  logic [2:0]        bit_q;
  logic [6:0]        sh_q;
  logic [7:0]        byte_in, tx_q, rd_data, sr_q;
  logic [HI_W-1:0]   ahi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              ahalf_q, iswr_q, got_q, pend_q, srcst_q, oe_q;
  logic              wren_q, wrdi_q, srv_q;
  logic              active, byte_done, out_state, start, fill_clr, fill_we;

  assign active    = (st_q != ST_IDLE);
  assign byte_in   = {sh_q, mosi_s};
  assign byte_done = sck_rise && active && (bit_q == 3'd7);
  assign out_state = (st_q == ST_RDAT) || (st_q == ST_STAT);
  assign start     = cs_rise && (st_q == ST_WDAT) && (bit_q == 3'd0) && got_q && wr_permit && !busy;
  assign fill_clr  = byte_done && (st_q == ST_ADDR) && ahalf_q && iswr_q;
  assign fill_we   = byte_done && (st_q == ST_WDAT);

  spi_mem_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .fill_clr(fill_clr), .fill_we(fill_we),
    .fill_idx(ptr_q[PAGE_W-1:0]), .fill_data(byte_in), .start(start),
    .start_page(ptr_q[ADDR_W-1:PAGE_W]), .rd_addr(ptr_q), .rd_data(rd_data),
    .busy(busy), .done(cycle_done)
  );

  // Next-state decode
  always_comb begin
    st_nx = st_q;
    if (cs_rise) st_nx = ST_IDLE;
    else if (cs_fall) st_nx = ST_OPC;
    else if (byte_done) begin
      case (st_q)
        ST_OPC: begin
          if (busy && byte_in != OP_RDSR) st_nx = ST_DROP;
          else begin
            case (byte_in)
              OP_RDSR:           st_nx = ST_STAT;
              OP_WRSR:           st_nx = ST_SRDAT;
              OP_READ, OP_WRITE: st_nx = ST_ADDR;
              default:           st_nx = ST_DROP;
            endcase
          end
        end
        ST_ADDR: if (ahalf_q) st_nx = iswr_q ? ST_WDAT : ST_RDAT;
        default: st_nx = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  bit_q <= '0;   sh_q <= '0;    ahi_q <= '0;
      ahalf_q <= 1'b0;  iswr_q <= 1'b0; got_q <= 1'b0; pend_q <= 1'b0;
      srcst_q <= 1'b0;  oe_q <= 1'b0;   ptr_q <= '0;   tx_q <= '0;
      sr_q <= '0;       wren_q <= 1'b0; wrdi_q <= 1'b0; srv_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      wren_q <= byte_done && (st_q == ST_OPC) && !busy && (byte_in == OP_WREN);
      wrdi_q <= byte_done && (st_q == ST_OPC) && !busy && (byte_in == OP_WRDI);
      srv_q  <= cs_rise && (st_q == ST_SRDAT) && (bit_q == 3'd0) && got_q;
      if (cs_fall || cs_rise) begin
        bit_q <= '0; oe_q <= 1'b0; pend_q <= 1'b0; got_q <= 1'b0; ahalf_q <= 1'b0;
      end else begin
        if (sck_rise && active) begin
          sh_q  <= byte_in[6:0];
          bit_q <= bit_q + 3'd1;
        end
        if (byte_done) begin
          case (st_q)
            ST_OPC: begin
              iswr_q <= (byte_in == OP_WRITE);
              if (byte_in == OP_RDSR) begin pend_q <= 1'b1; srcst_q <= 1'b1; end
            end
            ST_ADDR: begin
              if (!ahalf_q) begin
                ahalf_q <= 1'b1;
                ahi_q   <= byte_in[HI_W-1:0];
              end else begin
                ptr_q <= {ahi_q, byte_in};
                if (!iswr_q) begin pend_q <= 1'b1; srcst_q <= 1'b0; end
              end
            end
            ST_RDAT, ST_STAT: pend_q <= 1'b1;
            ST_WDAT: begin
              ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
              got_q <= 1'b1;
            end
            ST_SRDAT: if (!got_q) begin sr_q <= byte_in; got_q <= 1'b1; end
            default: ;
          endcase
        end
        if (sck_fall && out_state) begin
          if (pend_q) begin
            tx_q   <= srcst_q ? {stat_hi, busy} : rd_data;
            oe_q   <= 1'b1;
            pend_q <= 1'b0;
            if (!srcst_q) ptr_q <= ptr_q + ADDR_W'(1);
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso        = tx_q[7];
  assign miso_oe     = oe_q;
  assign tgt_addr    = ptr_q;
  assign cmd_wren    = wren_q;
  assign cmd_wrdi    = wrdi_q;
  assign sr_wr_valid = srv_q;
  assign sr_wr_data  = sr_q;

  a_r1_quiet_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !miso_oe);
  a_r12_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |-> !miso_oe);
  a_r8_no_enable_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_wren);
  a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wren && cmd_wrdi));
endmodule

// File: tb/spi_mem_ctrl_tb_top.sv
module spi_mem_ctrl_tb_top;
  localparam int WRC = 4000;
  localparam int H   = 8;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, csn = 1'b1, mosi = 1'b0, wr_permit = 1'b1;
  logic [6:0] stat_hi = 7'b1010010;
  logic miso, miso_oe, busy, cycle_done, cmd_wren, cmd_wrdi, sr_wr_valid;
  logic [9:0] tgt_addr;
  logic [7:0] sr_wr_data;

  always #4 clk = ~clk;

  spi_mem_ctrl #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi), .miso(miso),
    .miso_oe(miso_oe), .stat_hi(stat_hi), .wr_permit(wr_permit), .tgt_addr(tgt_addr),
    .busy(busy), .cycle_done(cycle_done), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data)
  );

  int checks = 0, errors = 0;
  string cur_req = "R2";
  logic cpol = 1'b0;
  logic mon_en = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] wq[$];
  logic [7:0] mon_sh;
  int mon_n = 0;
  int wren_n = 0, wrdi_n = 0, srv_n = 0, done_n = 0, start_n = 0, oe_n = 0, bcnt = 0, last_len = 0;
  logic [7:0] last_sr = 8'h00;
  logic busy_d = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  // Port monitor: counts pulses and measures busy windows
  always @(negedge clk) begin
    if (cmd_wren) wren_n++;
    if (cmd_wrdi) wrdi_n++;
    if (sr_wr_valid) begin srv_n++; last_sr = sr_wr_data; end
    if (cycle_done) done_n++;
    if (miso_oe) oe_n++;
    if (busy && !busy_d) start_n++;
    if (busy) bcnt++;
    else if (bcnt != 0) begin last_len = bcnt; bcnt = 0; end
    busy_d = busy;
  end

  // Scoreboard monitor: collects serial bytes and pops expected values
  always @(posedge sck) begin
    if (mon_en) begin
      chk({cur_req, " drive"}, {31'd0, miso_oe}, 32'd1);
      mon_sh = {mon_sh[6:0], miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() > 0) chk({cur_req, " data"}, {24'd0, mon_sh}, {24'd0, exp_q.pop_front()});
        else chk({cur_req, " unexpected byte"}, {24'd0, mon_sh}, 32'hFFFF_FFFF);
      end
    end
  end

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; mosi = b[i];
      repeat (H) @(negedge clk);
      sck = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic t_begin();
    sck = cpol;
    repeat (H) @(negedge clk);
    csn = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic t_end();
    if (!cpol) sck = 1'b0;
    repeat (H) @(negedge clk);
    csn = 1'b1;
    repeat (3 * H) @(negedge clk);
  endtask

  // Caller pushes expected bytes into exp_q first
  task automatic read_run(input logic [15:0] a, input int n);
    t_begin();
    send_bits(8'h03, 8); send_bits(a[15:8], 8); send_bits(a[7:0], 8);
    mon_n = 0; mon_en = 1'b1;
    for (int i = 0; i < n; i++) send_bits(8'h00, 8);
    mon_en = 1'b0;
    t_end();
    chk({cur_req, " all bytes seen"}, exp_q.size(), 0);
  endtask

  // Caller pushes data bytes into wq first
  task automatic write_run(input logic [15:0] a);
    t_begin();
    send_bits(8'h02, 8); send_bits(a[15:8], 8); send_bits(a[7:0], 8);
    while (wq.size() > 0) send_bits(wq.pop_front(), 8);
    t_end();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int o, w, s;
    repeat (5) @(negedge clk);
    chk("R1 reset oe", {31'd0, miso_oe}, 0);
    chk("R1 reset busy", {31'd0, busy}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 enable / disable pulses
    t_begin(); send_bits(8'h06, 8); t_end();
    chk("R10 wren", wren_n, 1);
    t_begin(); send_bits(8'h04, 8); t_end();
    chk("R10 wrdi", wrdi_n, 1);
    chk("R1 deselected oe", {31'd0, miso_oe}, 0);

    // R4 page write
    wq = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
    write_run(16'h0040);
    chk("R4 busy up", {31'd0, busy}, 1);
    chk("R4 one start", start_n, 1);

    // R9 status read during busy
    cur_req = "R9";
    exp_q = '{8'hA5, 8'hA5};
    t_begin(); send_bits(8'h05, 8);
    mon_n = 0; mon_en = 1'b1;
    send_bits(8'h00, 8); send_bits(8'h00, 8);
    mon_en = 1'b0; t_end();
    chk("R9 all bytes seen", exp_q.size(), 0);

    // R8 other commands ignored while busy
    o = oe_n; w = wren_n;
    t_begin(); send_bits(8'h03, 8); send_bits(8'h00, 8); send_bits(8'h40, 8);
    send_bits(8'h00, 8); send_bits(8'h00, 8); t_end();
    chk("R8 read silent", oe_n, o);
    t_begin(); send_bits(8'h06, 8); t_end();
    chk("R8 wren ignored", wren_n, w);
    wq = '{8'hFF};
    write_run(16'h0040);
    chk("R8 still busy", {31'd0, busy}, 1);
    wait_idle();
    chk("R4 busy length", last_len, WRC);
    chk("R4 done pulse", done_n, 1);
    chk("R8 no second start", start_n, 1);

    cur_req = "R9";
    exp_q = '{8'hA4};
    t_begin(); send_bits(8'h05, 8);
    mon_n = 0; mon_en = 1'b1; send_bits(8'h00, 8); mon_en = 1'b0; t_end();
    chk("R9 idle status seen", exp_q.size(), 0);

    cur_req = "R2";
    exp_q = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
    read_run(16'h0040, 4);
    cur_req = "R2 high address bits ignored";
    exp_q = '{8'hA0};
    read_run(16'hFC40, 1);

    // R5 page wrap
    cur_req = "R5";
    wq = '{8'h11, 8'h22, 8'h33, 8'h44};
    write_run(16'h007E); wait_idle();
    exp_q = '{8'h11, 8'h22}; read_run(16'h007E, 2);
    exp_q = '{8'h33, 8'h44}; read_run(16'h0060, 2);

    // R3 read wraps top to zero
    cur_req = "R3";
    wq = '{8'h5A, 8'h5B}; write_run(16'h03FE); wait_idle();
    wq = '{8'h6C};        write_run(16'h0000); wait_idle();
    exp_q = '{8'h5A, 8'h5B, 8'h6C}; read_run(16'h03FE, 3);

    // R6 aborted writes
    cur_req = "R6";
    s = start_n;
    t_begin(); send_bits(8'h02, 8); send_bits(8'h00, 8); send_bits(8'h40, 8);
    send_bits(8'hF0, 8); send_bits(8'hFF, 3); t_end();
    chk("R6 mid-byte no start", start_n, s);
    t_begin(); send_bits(8'h02, 8); send_bits(8'h00, 8); send_bits(8'h40, 8); t_end();
    chk("R6 no data no start", start_n, s);
    exp_q = '{8'hA0}; read_run(16'h0040, 1);

    // R7 permission withheld
    cur_req = "R7";
    wr_permit = 1'b0;
    wq = '{8'hEE}; write_run(16'h0041);
    chk("R7 no start", start_n, s);
    wr_permit = 1'b1;
    exp_q = '{8'hA1}; read_run(16'h0041, 1);

    // R11 status write request
    t_begin(); send_bits(8'h01, 8); send_bits(8'h8C, 8); send_bits(8'h11, 8); t_end();
    chk("R11 pulse", srv_n, 1);
    chk("R11 data", {24'd0, last_sr}, 32'h8C);
    t_begin(); send_bits(8'h01, 8); send_bits(8'h33, 5); t_end();
    chk("R11 partial ignored", srv_n, 1);

    // R12 unknown command
    o = oe_n; w = wren_n;
    t_begin(); send_bits(8'h07, 8); send_bits(8'h03, 8); send_bits(8'h00, 8);
    send_bits(8'h40, 8); send_bits(8'h06, 8); send_bits(8'h00, 8); t_end();
    chk("R12 no output", oe_n, o);
    chk("R12 no pulse", wren_n, w);
    cur_req = "R12 recovers";
    exp_q = '{8'hA1}; read_run(16'h0041, 1);

    // R2 clock idling high
    cur_req = "R2 idle-high clock";
    cpol = 1'b1; sck = 1'b1;
    repeat (4 * H) @(negedge clk);
    exp_q = '{8'hA2, 8'hA3}; read_run(16'h0042, 2);
    cpol = 1'b0; sck = 1'b0;
    repeat (4 * H) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule